// File: doc/BRIEF.md
# UART Banked Register Access Decoder

This block sits between a narrow host port (three address bits, byte-wide data) and a UART whose register set is larger than eight locations. It keeps track of which bank the host currently sees and routes each access to the right place. Registers that live in the serial datapath stay outside the block: the datapath feeds their read values in as plain inputs and receives one-hot read and write strobes from the block. The line control register, the scratch/index register, the FIFO control register and every bank-switched or indexed register are held here and driven out as ports.

Writing a special key value to the line control location (address 3) opens a hidden bank. In that bank, five addresses reach the flow-control feature and character-match registers. Any other value written to address 3 closes the bank. Outside the hidden bank, a second route reaches eight more configuration registers. The host writes an index to the scratch register, then uses the index data port to reach the register that index selects. The FIFO control register cannot be read at its own address. Its last written value can be read back through one reserved index.

Top module: `uart_bank_decode`

## Requirements
- R1: After reset, the line control value, the index register, the FIFO control value and all eight indexed registers are 0x00. The block is in the normal bank, so reads of address 3 and address 7 return 0x00.
- R2: Writing 0xBF to address 3 opens the hidden bank and sets line control bit 7. Bits 6:0 keep their previous value, so `line_ctl` goes from 0x1B to 0x9B.
- R3: While the hidden bank is open, addresses 2, 4, 5, 6 and 7 read and write the feature register, XON A, XON B, XOFF A and XOFF B. These accesses raise no strobe and leave the index register untouched. Addresses 0, 1 and 3 keep their normal meaning.
- R4: Writing any value other than 0xBF to address 3 stores the full value in line control and returns the block to the normal bank.
- R5: In the normal bank, the index written at address 7 selects the target of a write to address 5. The index map is:
  - 0: additional control
  - 1: prescaler
  - 2: sample clock
  - 3: clock select
  - 4: transmit trigger
  - 5: receive trigger
  - 6: low flow threshold
  - 7: high flow threshold

  A write to address 5 raises no strobe.
- R6: In the normal bank, a read of address 5 behaves as follows:
  - Additional control bit 6 set: the read returns the indexed register and raises no strobe.
  - Bit 6 clear: the read returns `lsr_in` and raises strobe bit 5.
- R7: In the normal bank, a write to address 2 captures the FIFO control value and raises strobe bit 2. A read of address 2 returns `isr_in`. Index 0x0F, read through address 5, returns the captured FIFO control value. Writes at index 0x0F are ignored.
- R8: Index values 0x08 to 0x0E and 0x10 to 0xFF are undefined. Writes to them change no register, and reads from them return 0x00.
- R9: Write strobe bit N (and likewise read strobe bit N) is raised in the same cycle as an access to address N that reaches a normal-bank register. Access to the index data port raises no write strobe. The hidden-bank registers raise no strobe of either kind. At most one bit of each strobe vector is high.
- R10: In the normal bank, reads of addresses 0, 1, 4 and 6 return `rhr_in`, `ier_in`, `mcr_in` and `msr_in`. Reads of addresses 3 and 7 return the line control and index registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rhr_in | input | 8 | Receive holding value from datapath |
| ier_in | input | 8 | Interrupt enable value |
| isr_in | input | 8 | Interrupt status value |
| mcr_in | input | 8 | Modem control value |
| lsr_in | input | 8 | Line status value |
| msr_in | input | 8 | Modem status value |
| wr_stb | output | 8 | One-hot normal-bank write strobe |
| rd_stb | output | 8 | One-hot normal-bank read strobe |
| line_ctl | output | 8 | Line control register |
| fifo_ctl | output | 8 | FIFO control register |
| ext_feat | output | 8 | Enhanced feature register |
| xon_a | output | 8 | XON character A |
| xon_b | output | 8 | XON character B |
| xoff_a | output | 8 | XOFF character A |
| xoff_b | output | 8 | XOFF character B |
| add_ctl | output | 8 | Additional control (index 0) |
| prescale | output | 8 | Prescaler (index 1) |
| sample_ctl | output | 8 | Sample clock (index 2) |
| clk_sel | output | 8 | Clock select (index 3) |
| tx_trig | output | 8 | Transmit trigger (index 4) |
| rx_trig | output | 8 | Receive trigger (index 5) |
| flow_lo | output | 8 | Low flow threshold (index 6) |
| flow_hi | output | 8 | High flow threshold (index 7) |

## Verification
A wrong bank flag shows up on the very next access:
- A stuck-closed bank makes addresses 2 and 4 to 7 raise strobes and return datapath inputs.
- A stuck-open bank makes writes land in the XON/XOFF outputs instead of the index register.

A corrupted index register does not show by itself. It is exposed by the following address-5 write or read, through the wrong output port changing or a wrong or non-zero read value. A lost FIFO control capture stays hidden until index 0x0F is read back.

// File: rtl/uart_bank_decode.sv
module uart_bank_decode #(
  parameter int             DW        = 8,
  parameter logic [DW-1:0]  BANK_KEY  = 8'hBF,
  parameter logic [DW-1:0]  FCR_VIEW  = 8'h0F,
  parameter int             RD_EN_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] rhr_in,
  input  logic [DW-1:0] ier_in,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] mcr_in,
  input  logic [DW-1:0] lsr_in,
  input  logic [DW-1:0] msr_in,
  output logic [7:0]    wr_stb,
  output logic [7:0]    rd_stb,
  output logic [DW-1:0] line_ctl,
  output logic [DW-1:0] fifo_ctl,
  output logic [DW-1:0] ext_feat,
  output logic [DW-1:0] xon_a,
  output logic [DW-1:0] xon_b,
  output logic [DW-1:0] xoff_a,
  output logic [DW-1:0] xoff_b,
  output logic [DW-1:0] add_ctl,
  output logic [DW-1:0] prescale,
  output logic [DW-1:0] sample_ctl,
  output logic [DW-1:0] clk_sel,
  output logic [DW-1:0] tx_trig,
  output logic [DW-1:0] rx_trig,
  output logic [DW-1:0] flow_lo,
  output logic [DW-1:0] flow_hi
);
  localparam int         NIDX  = 8;
  localparam int         IW    = $clog2(NIDX);
  localparam int         NEXT  = 5;
  localparam logic [2:0] A_FCR = 3'd2;
  localparam logic [2:0] A_LCR = 3'd3;
  localparam logic [2:0] A_IDX = 3'd5;
  localparam logic [2:0] A_SPR = 3'd7;

  logic [DW-1:0] lcr_q, spr_q, fcr_q;
  logic          bf_mode;
  logic [DW-1:0] ext_q [NEXT];
  logic [DW-1:0] idx_q [NIDX];

  logic          hid_hit, port_hit, idx_valid, idx_rd_on;
  logic [2:0]    hid_slot;
  logic [IW-1:0] idx_sel;

  always_comb begin
    hid_slot = 3'd0;
    case (addr)
      3'd2:    hid_slot = 3'd0;
      3'd4:    hid_slot = 3'd1;
      3'd5:    hid_slot = 3'd2;
      3'd6:    hid_slot = 3'd3;
      3'd7:    hid_slot = 3'd4;
      default: hid_slot = 3'd0;
    endcase
  end

  assign hid_hit   = bf_mode && (addr == A_FCR || addr >= 3'd4);
  assign port_hit  = !bf_mode && addr == A_IDX;
  assign idx_valid = spr_q < DW'(NIDX);
  assign idx_sel   = spr_q[IW-1:0];
  assign idx_rd_on = port_hit && idx_q[0][RD_EN_BIT];

  assign wr_stb = (wr_en && !hid_hit && !port_hit) ? (8'd1 << addr) : 8'd0;
  assign rd_stb = (rd_en && !hid_hit && !idx_rd_on) ? (8'd1 << addr) : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr_q   <= '0;
      spr_q   <= '0;
      fcr_q   <= '0;
      bf_mode <= 1'b0;
      for (int i = 0; i < NEXT; i++) ext_q[i] <= '0;
      for (int i = 0; i < NIDX; i++) idx_q[i] <= '0;
    end else if (wr_en) begin
      if (addr == A_LCR) begin
        if (wdata == BANK_KEY) begin
          lcr_q[DW-1] <= 1'b1;
          bf_mode     <= 1'b1;
        end else begin
          lcr_q   <= wdata;
          bf_mode <= 1'b0;
        end
      end else if (hid_hit) begin
        ext_q[hid_slot] <= wdata;
      end else if (addr == A_SPR) begin
        spr_q <= wdata;
      end else if (addr == A_FCR) begin
        fcr_q <= wdata;
      end else if (port_hit && idx_valid) begin
        idx_q[idx_sel] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hid_hit) begin
      rdata = ext_q[hid_slot];
    end else if (idx_rd_on) begin
      if (idx_valid)             rdata = idx_q[idx_sel];
      else if (spr_q == FCR_VIEW) rdata = fcr_q;
      else                       rdata = '0;
    end else begin
      case (addr)
        3'd0:    rdata = rhr_in;
        3'd1:    rdata = ier_in;
        3'd2:    rdata = isr_in;
        3'd3:    rdata = lcr_q;
        3'd4:    rdata = mcr_in;
        3'd5:    rdata = lsr_in;
        3'd6:    rdata = msr_in;
        default: rdata = spr_q;
      endcase
    end
  end

  assign line_ctl   = lcr_q;
  assign fifo_ctl   = fcr_q;
  assign ext_feat   = ext_q[0];
  assign xon_a      = ext_q[1];
  assign xon_b      = ext_q[2];
  assign xoff_a     = ext_q[3];
  assign xoff_b     = ext_q[4];
  assign add_ctl    = idx_q[0];
  assign prescale   = idx_q[1];
  assign sample_ctl = idx_q[2];
  assign clk_sel    = idx_q[3];
  assign tx_trig    = idx_q[4];
  assign rx_trig    = idx_q[5];
  assign flow_lo    = idx_q[6];
  assign flow_hi    = idx_q[7];
endmodule

// File: rtl/uart_bank_decode_chk.sv
module uart_bank_decode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] wr_stb,
  input logic [7:0] rd_stb,
  input logic [7:0] line_ctl,
  input logic [7:0] fifo_ctl,
  input logic [7:0] add_ctl,
  input logic [7:0] spr_q,
  input logic       bf_mode
);
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb) && $onehot0(rd_stb));

  p_key_keeps_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata == 8'hBF)
      |=> (line_ctl[7] && line_ctl[6:0] == $past(line_ctl[6:0])));

  p_lcr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd3 && wdata != 8'hBF) |=> (line_ctl == $past(wdata) && !bf_mode));

  p_hidden_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_en) && bf_mode && (addr == 3'd2 || addr >= 3'd4))
      |-> (wr_stb == 8'd0 && rd_stb == 8'd0));

  p_fcr_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bf_mode && addr == 3'd2) |=> fifo_ctl == $past(wdata));

  p_undef_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !bf_mode && addr == 3'd5 && add_ctl[6] && spr_q >= 8'd8 && spr_q != 8'h0F)
      |-> rdata == 8'd0);
endmodule

bind uart_bank_decode uart_bank_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .line_ctl(line_ctl), .fifo_ctl(fifo_ctl), .add_ctl(add_ctl),
  .spr_q(spr_q), .bf_mode(bf_mode)
);

// File: tb/uart_bank_decode_tb.sv
module uart_bank_decode_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, wr_stb, rd_stb;
  logic [7:0] rhr_in = 8'h11, ier_in = 8'h22, isr_in = 8'hC1, mcr_in = 8'h44;
  logic [7:0] lsr_in = 8'h60, msr_in = 8'h76;
  logic [7:0] line_ctl, fifo_ctl, ext_feat, xon_a, xon_b, xoff_a, xoff_b;
  logic [7:0] add_ctl, prescale, sample_ctl, clk_sel, tx_trig, rx_trig, flow_lo, flow_hi;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  logic [7:0] idx_exp [8];

  always #5 clk = ~clk;

  uart_bank_decode u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .rhr_in(rhr_in), .ier_in(ier_in),
    .isr_in(isr_in), .mcr_in(mcr_in), .lsr_in(lsr_in), .msr_in(msr_in),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .line_ctl(line_ctl), .fifo_ctl(fifo_ctl),
    .ext_feat(ext_feat), .xon_a(xon_a), .xon_b(xon_b), .xoff_a(xoff_a),
    .xoff_b(xoff_b), .add_ctl(add_ctl), .prescale(prescale),
    .sample_ctl(sample_ctl), .clk_sel(clk_sel), .tx_trig(tx_trig),
    .rx_trig(rx_trig), .flow_lo(flow_lo), .flow_hi(flow_hi)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input logic [7:0] stb, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1; wr_en = 0;
    exp_q.push_back({1'b1, stb, exp});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic [7:0] stb, input string tag);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; rd_en = 0;
    exp_q.push_back({1'b0, stb, 8'h00});
    tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 0;
    #2;
  endtask

  always @(negedge clk) begin
    #2;
    if (rd_en || wr_en) begin
      logic [16:0] it;
      string t;
      it = exp_q.pop_front();
      t = tag_q.pop_front();
      if (it[16]) begin
        chk(rdata, it[7:0], {t, " rdata"});
        chk(rd_stb, it[15:8], {t, " rd_stb"});
      end else begin
        chk(wr_stb, it[15:8], {t, " wr_stb"});
      end
    end
  end

  task automatic chk_idx(input string tag);
    chk(add_ctl, idx_exp[0], tag);
    chk(prescale, idx_exp[1], tag);
    chk(sample_ctl, idx_exp[2], tag);
    chk(clk_sel, idx_exp[3], tag);
    chk(tx_trig, idx_exp[4], tag);
    chk(rx_trig, idx_exp[5], tag);
    chk(flow_lo, idx_exp[6], tag);
    chk(flow_hi, idx_exp[7], tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) idx_exp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(line_ctl, 8'h00, "R1 line_ctl");
    chk(fifo_ctl, 8'h00, "R1 fifo_ctl");
    chk_idx("R1 indexed");
    rd(3'd3, 8'h00, 8'h08, "R1 lcr read");
    rd(3'd7, 8'h00, 8'h80, "R1 index read");
    rd(3'd5, lsr_in, 8'h20, "R6 lsr when disabled");

    rd(3'd0, rhr_in, 8'h01, "R10 rhr");
    rd(3'd1, ier_in, 8'h02, "R10 ier");
    rd(3'd2, isr_in, 8'h04, "R7 isr at 2");
    rd(3'd4, mcr_in, 8'h10, "R10 mcr");
    rd(3'd6, msr_in, 8'h40, "R10 msr");

    wr(3'd3, 8'h1B, 8'h08, "R4 lcr write");
    chk(line_ctl, 8'h1B, "R4 lcr stored");
    wr(3'd3, 8'hBF, 8'h08, "R2 key write");
    chk(line_ctl, 8'h9B, "R2 low bits kept");
    rd(3'd3, 8'h9B, 8'h08, "R2 lcr read");

    wr(3'd2, 8'hA5, 8'h00, "R3 efr");
    wr(3'd4, 8'h11, 8'h00, "R3 xon a");
    wr(3'd5, 8'h13, 8'h00, "R3 xon b");
    wr(3'd6, 8'h19, 8'h00, "R3 xoff a");
    wr(3'd7, 8'h93, 8'h00, "R3 xoff b");
    chk(ext_feat, 8'hA5, "R3 ext_feat");
    chk(xon_a, 8'h11, "R3 xon_a");
    chk(xon_b, 8'h13, "R3 xon_b");
    chk(xoff_a, 8'h19, "R3 xoff_a");
    chk(xoff_b, 8'h93, "R3 xoff_b");
    chk(fifo_ctl, 8'h00, "R3 fcr untouched");
    chk_idx("R3 indexed untouched");
    rd(3'd2, 8'hA5, 8'h00, "R3 efr read");
    rd(3'd5, 8'h13, 8'h00, "R3 xon b read");
    rd(3'd7, 8'h93, 8'h00, "R3 xoff b read");
    rd(3'd0, rhr_in, 8'h01, "R3 addr0 normal");
    wr(3'd1, 8'h05, 8'h02, "R9 hidden ier strobe");

    wr(3'd3, 8'h03, 8'h08, "R4 exit");
    chk(line_ctl, 8'h03, "R4 full value");
    rd(3'd7, 8'h00, 8'h80, "R3 index untouched");
    rd(3'd2, isr_in, 8'h04, "R4 normal isr");

    wr(3'd7, 8'h00, 8'h80, "R5 idx0");
    wr(3'd5, 8'h00, 8'h00, "R5 acr");
    for (int i = 1; i < 8; i++) begin
      wr(3'd7, 8'(i), 8'h80, "R5 index");
      wr(3'd5, 8'(8'h10 * i + 3), 8'h00, "R5 port write");
      idx_exp[i] = 8'(8'h10 * i + 3);
    end
    chk_idx("R5 indexed outputs");
    rd(3'd5, lsr_in, 8'h20, "R6 disabled read");

    wr(3'd7, 8'h00, 8'h80, "R6 idx0");
    wr(3'd5, 8'h40, 8'h00, "R6 enable");
    idx_exp[0] = 8'h40;
    chk(add_ctl, 8'h40, "R5 add_ctl");
    wr(3'd7, 8'h03, 8'h80, "R6 idx3");
    rd(3'd5, 8'h33, 8'h00, "R6 indexed read");
    wr(3'd7, 8'h00, 8'h80, "R6 idx0");
    rd(3'd5, 8'h40, 8'h00, "R6 acr read");

    wr(3'd2, 8'hC7, 8'h04, "R7 fcr write");
    chk(fifo_ctl, 8'hC7, "R7 fifo_ctl");
    rd(3'd2, isr_in, 8'h04, "R7 write-only");
    wr(3'd7, 8'h0F, 8'h80, "R7 view idx");
    rd(3'd5, 8'hC7, 8'h00, "R7 view read");
    wr(3'd5, 8'h00, 8'h00, "R7 view write");
    chk(fifo_ctl, 8'hC7, "R7 view write ignored");
    rd(3'd5, 8'hC7, 8'h00, "R7 view reread");

    wr(3'd7, 8'h08, 8'h80, "R8 idx8");
    wr(3'd5, 8'hFF, 8'h00, "R8 undef write");
    rd(3'd5, 8'h00, 8'h00, "R8 undef read");
    wr(3'd7, 8'hFE, 8'h80, "R8 idxFE");
    wr(3'd5, 8'h5A, 8'h00, "R8 undef write");
    rd(3'd5, 8'h00, 8'h00, "R8 undef read FE");
    chk_idx("R8 indexed unchanged");

    wr(3'd3, 8'hBF, 8'h08, "R2 reopen");
    chk(line_ctl, 8'h83, "R2 bits kept 03");
    wr(3'd5, 8'h77, 8'h00, "R3 xon b again");
    chk(xon_b, 8'h77, "R3 xon_b rewrite");
    chk_idx("R3 no indexed write");
    wr(3'd3, 8'h00, 8'h08, "R4 exit zero");
    rd(3'd7, 8'hFE, 8'h80, "R4 normal index");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule